// File: doc/BRIEF.md
# Dual-Line Interrupt Router

This block gathers event pulses from a bus-controller core and turns them into interrupt requests for a system interrupt controller. Each event pulse sets a sticky flag. Three registers decide whether a flag raises a request and on which of two request lines it appears: a per-source enable mask, a per-source line select, and a per-line gate. Software reads the flags to find the cause and clears a flag by writing 1 to its bit.

A second, two-bit flag group holds a bus-error event and a debug-reception event. This group has its own request output. Its enable mask is changed through two registers: writing 1 to a bit of the first register sets that enable, and writing 1 to a bit of the second register clears it. All three request outputs are registered.

The register port is a single-cycle write strobe with a 3-bit word address. Read data is combinational from the address. The register words are: 0 main flags, 1 main enable, 2 line select, 3 line gate, 4 auxiliary flags, 5 auxiliary enable set, 6 auxiliary enable clear.

Top module: `irq_router_top`

## Requirements
- R1: A 1 on `src_evt_i[i]` sets main flag i at the next clock edge. The flag stays set until it is cleared. Main flags read at address 0 in bits [NUM_SRC-1:0].
- R2: Writing address 0 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged. An event on a bit in the same cycle as its clear leaves that bit set.
- R3: Address 1 is a plain read/write enable mask: a written 1 enables the source and a written 0 disables it. Reading the address returns the current mask.
- R4: Address 2 selects the line for each source: bit i = 0 routes source i to line 0, and bit i = 1 routes it to line 1. The register reads back as written.
- R5: Address 3 bits [1:0] gate line 0 and line 1. They read back as written and are 0 after reset.
- R6: `irq_line_o[l]` is 1 one clock after a cycle in which some flag is set, enabled and routed to line l, and line l is gated on. Otherwise it is 0 one clock after that cycle.
- R7: Auxiliary flags at address 4 (bit 0 bus error, bit 1 debug reception) are set by `aux_evt_i`. They clear on a write of 1 to their bit, and an event in the same cycle wins over the clear.
- R8: Writing 1 to a bit at address 5 sets that auxiliary enable, and writing 1 to a bit at address 6 clears it. Written 0 bits have no effect. Both addresses read the current auxiliary enable mask in bits [1:0].
- R9: `irq_aux_o` is 1 one clock after a cycle in which some auxiliary flag is set and enabled, and 0 one clock after any other cycle.
- R10: A synchronous active-high reset clears all flags, masks, selects, line gates and request outputs.
- R11: Address 7 reads 0, and writes to it change no state. Register bits above the defined fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt_i | input | NUM_SRC | Main event pulses, one per source |
| aux_evt_i | input | 2 | Bus-error (bit 0) and debug-reception (bit 1) event pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_line_o | output | 2 | Request lines 0 and 1 |
| irq_aux_o | output | 1 | Auxiliary request |

## Verification
Flags, masks, selects and gates take a new value at the edge that samples an event or write, so a read at the following falling edge must already show it. A request output changes one edge later than the state that causes it. For each step, the bench first computes the expected requests from its model state as it stood before the edge, then advances the model, and compares both requests and read data at the next falling edge. This keeps the one-edge lag of the requests separate from the zero-lag state updates.

// File: rtl/irq_rt_pkg.sv
`timescale 1ns/1ps
package irq_rt_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;
    localparam int LINE_N = 2;
    localparam int AUX_N  = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_FLAGS  = 3'd0,
        ADR_EN     = 3'd1,
        ADR_SEL    = 3'd2,
        ADR_GATE   = 3'd3,
        ADR_AFLAGS = 3'd4,
        ADR_AENSET = 3'd5,
        ADR_AENCLR = 3'd6,
        ADR_NONE   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic      wr;
        reg_addr_e addr;
        logic [REG_W-1:0] wdata;
    } reg_req_t;

    typedef struct packed {
        logic flags;
        logic en;
        logic sel;
        logic gate;
        logic aflags;
        logic aenset;
        logic aenclr;
    } wr_hit_t;

    function automatic wr_hit_t decode_write(input reg_req_t r);
        wr_hit_t h;
        h        = '0;
        h.flags  = r.wr && (r.addr == ADR_FLAGS);
        h.en     = r.wr && (r.addr == ADR_EN);
        h.sel    = r.wr && (r.addr == ADR_SEL);
        h.gate   = r.wr && (r.addr == ADR_GATE);
        h.aflags = r.wr && (r.addr == ADR_AFLAGS);
        h.aenset = r.wr && (r.addr == ADR_AENSET);
        h.aenclr = r.wr && (r.addr == ADR_AENCLR);
        return h;
    endfunction

endpackage

// File: rtl/irq_rt_flag_bank.sv
`timescale 1ns/1ps
// Sticky flags, write-1-to-clear; an event in the clear cycle wins.
module irq_rt_flag_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    logic [W-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & ~clr_i) | evt_i;
    end

    assign flag_o = flag_q;

    // R1: every pulsed event is visible as a flag one edge later
    p_evt_sets_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

    // R2: bits not written with 1 never drop
    p_w0_keeps_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((($past(flag_q) & ~$past(clr_i))) & ~flag_q) == '0));

    // R2: cleared bits without a same-cycle event are gone
    p_clr_drops_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/irq_rt_mask_reg.sv
`timescale 1ns/1ps
// Generic set/clear mask register; plain writes are expressed as set+clear.
module irq_rt_mask_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_i) | set_i;
    end

    assign q_o = q;

    // R8: a set request is honoured unless a clear of the same bit coincides
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
endmodule

// File: rtl/irq_rt_line_router.sv
`timescale 1ns/1ps
// Routes enabled flags to two gated, registered request lines.
module irq_rt_line_router
    import irq_rt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      flag_i,
    input  logic [W-1:0]      en_i,
    input  logic [W-1:0]      sel_i,
    input  logic [LINE_N-1:0] gate_i,
    output logic [LINE_N-1:0] irq_o
);
    logic [W-1:0]      active;
    logic [LINE_N-1:0] pend;
    logic [LINE_N-1:0] irq_q;

    assign active = flag_i & en_i;

    for (genvar l = 0; l < LINE_N; l++) begin : g_line
        logic [W-1:0] member;
        assign member  = (l == 0) ? ~sel_i : sel_i;
        assign pend[l] = (|(active & member)) & gate_i[l];

        // R5: an ungated line is low on the next edge
        p_gate_off_r5: assert property (@(posedge clk) disable iff (rst)
            !gate_i[l] |=> !irq_o[l]);

        // R6: a pending routed source raises its line
        p_raise_r6: assert property (@(posedge clk) disable iff (rst)
            ((|(flag_i & en_i & member)) && gate_i[l]) |=> irq_o[l]);
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= '0;
        else     irq_q <= pend;
    end

    assign irq_o = irq_q;

    // R6: with nothing enabled and set, both lines fall
    p_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (active == '0) |=> (irq_o == '0));
endmodule

// File: rtl/irq_router_top.sv
`timescale 1ns/1ps
module irq_router_top
    import irq_rt_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_evt_i,
    input  logic [AUX_N-1:0]   aux_evt_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]   reg_rdata_o,
    output logic [LINE_N-1:0]  irq_line_o,
    output logic               irq_aux_o
);
    reg_req_t            req;
    wr_hit_t             hit;
    logic [NUM_SRC-1:0]  wd_src;
    logic [AUX_N-1:0]    wd_aux;
    logic [LINE_N-1:0]   wd_gate;
    logic                unused_wdata;

    assign req.wr    = reg_wr_i;
    assign req.addr  = reg_addr_e'(reg_addr_i);
    assign req.wdata = reg_wdata_i;
    assign hit       = decode_write(req);

    assign wd_src       = req.wdata[NUM_SRC-1:0];
    assign wd_aux       = req.wdata[AUX_N-1:0];
    assign wd_gate      = req.wdata[LINE_N-1:0];
    assign unused_wdata = ^reg_wdata_i;

    logic [NUM_SRC-1:0] flags, en_mask, sel_mask;
    logic [LINE_N-1:0]  gate;
    logic [AUX_N-1:0]   aflags, aen;

    irq_rt_flag_bank #(.W(NUM_SRC)) u_main_flags (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (src_evt_i),
        .clr_i  (hit.flags ? wd_src : '0),
        .flag_o (flags)
    );

    irq_rt_mask_reg #(.W(NUM_SRC)) u_en (
        .clk   (clk),
        .rst   (rst),
        .set_i (hit.en ? wd_src : '0),
        .clr_i (hit.en ? ~wd_src : '0),
        .q_o   (en_mask)
    );

    irq_rt_mask_reg #(.W(NUM_SRC)) u_sel (
        .clk   (clk),
        .rst   (rst),
        .set_i (hit.sel ? wd_src : '0),
        .clr_i (hit.sel ? ~wd_src : '0),
        .q_o   (sel_mask)
    );

    irq_rt_mask_reg #(.W(LINE_N)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .set_i (hit.gate ? wd_gate : '0),
        .clr_i (hit.gate ? ~wd_gate : '0),
        .q_o   (gate)
    );

    irq_rt_flag_bank #(.W(AUX_N)) u_aux_flags (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (aux_evt_i),
        .clr_i  (hit.aflags ? wd_aux : '0),
        .flag_o (aflags)
    );

    irq_rt_mask_reg #(.W(AUX_N)) u_aux_en (
        .clk   (clk),
        .rst   (rst),
        .set_i (hit.aenset ? wd_aux : '0),
        .clr_i (hit.aenclr ? wd_aux : '0),
        .q_o   (aen)
    );

    irq_rt_line_router #(.W(NUM_SRC)) u_router (
        .clk    (clk),
        .rst    (rst),
        .flag_i (flags),
        .en_i   (en_mask),
        .sel_i  (sel_mask),
        .gate_i (gate),
        .irq_o  (irq_line_o)
    );

    logic aux_irq_q;
    always_ff @(posedge clk) begin
        if (rst) aux_irq_q <= 1'b0;
        else     aux_irq_q <= |(aflags & aen);
    end
    assign irq_aux_o = aux_irq_q;

    always_comb begin
        reg_rdata_o = '0;
        unique case (req.addr)
            ADR_FLAGS:  reg_rdata_o[NUM_SRC-1:0] = flags;
            ADR_EN:     reg_rdata_o[NUM_SRC-1:0] = en_mask;
            ADR_SEL:    reg_rdata_o[NUM_SRC-1:0] = sel_mask;
            ADR_GATE:   reg_rdata_o[LINE_N-1:0]  = gate;
            ADR_AFLAGS: reg_rdata_o[AUX_N-1:0]   = aflags;
            ADR_AENSET: reg_rdata_o[AUX_N-1:0]   = aen;
            ADR_AENCLR: reg_rdata_o[AUX_N-1:0]   = aen;
            default:    reg_rdata_o = '0;
        endcase
    end

    // R9: no enabled auxiliary flag means the auxiliary request falls
    p_aux_idle_r9: assert property (@(posedge clk) disable iff (rst)
        ((aflags & aen) == '0) |=> !irq_aux_o);

    // R8: a clear-enable write of bit 0 removes that enable
    p_aux_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (hit.aenclr && reg_wdata_i[0]) |=> !aen[0]);

    // R10: reset leaves all requests low
    p_reset_r10: assert property (@(posedge clk)
        rst |=> (irq_line_o == '0) && !irq_aux_o);

    // R11: address 7 reads as zero
    p_hole_r11: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == 3'd7) |-> (reg_rdata_o == '0));
endmodule

// File: tb/test_irq_router_top.sv
`timescale 1ns/1ps
module test_irq_router_top;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] src_evt_i = '0;
    logic [1:0]  aux_evt_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [2:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [1:0]  irq_line_o;
    logic        irq_aux_o;

    always #2 clk = ~clk;

    irq_router_top #(.NUM_SRC(N)) i_irq_router_top (
        .clk(clk), .rst(rst), .src_evt_i(src_evt_i), .aux_evt_i(aux_evt_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_line_o(irq_line_o), .irq_aux_o(irq_aux_o)
    );

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    logic [N-1:0] m_flag, m_en, m_sel;
    logic [1:0]   m_gate, m_aflag, m_aen, e_irq;
    logic         e_airq;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] line_req();
        logic [N-1:0] a;
        logic [1:0] r;
        a = m_flag & m_en;
        r[0] = (|(a & ~m_sel)) & m_gate[0];
        r[1] = (|(a & m_sel)) & m_gate[1];
        return r;
    endfunction

    function automatic logic [31:0] mread(input logic [2:0] a);
        case (a)
            3'd0: return {16'h0, m_flag};
            3'd1: return {16'h0, m_en};
            3'd2: return {16'h0, m_sel};
            3'd3: return {30'h0, m_gate};
            3'd4: return {30'h0, m_aflag};
            3'd5, 3'd6: return {30'h0, m_aen};
            default: return 32'h0;
        endcase
    endfunction

    // One clock: drive at falling edge, advance model, check requests next fall.
    task automatic step(input logic [N-1:0] ev, input logic [1:0] aev,
                        input logic wr, input logic [2:0] a, input logic [31:0] wd);
        src_evt_i = ev; aux_evt_i = aev; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd;
        e_irq  = line_req();
        e_airq = |(m_aflag & m_aen);
        if (wr) begin
            case (a)
                3'd0: m_flag  = m_flag & ~wd[N-1:0];
                3'd1: m_en    = wd[N-1:0];
                3'd2: m_sel   = wd[N-1:0];
                3'd3: m_gate  = wd[1:0];
                3'd4: m_aflag = m_aflag & ~wd[1:0];
                3'd5: m_aen   = m_aen | wd[1:0];
                3'd6: m_aen   = m_aen & ~wd[1:0];
                default: ;
            endcase
        end
        m_flag  = m_flag | ev;
        m_aflag = m_aflag | aev;
        @(posedge clk);
        @(negedge clk);
        src_evt_i = '0; aux_evt_i = '0; reg_wr_i = 1'b0;
        chk("R6 irq_line_o", {30'h0, irq_line_o}, {30'h0, e_irq});
        chk("R9 irq_aux_o", {31'h0, irq_aux_o}, {31'h0, e_airq});
    endtask

    task automatic rd(input string tag, input logic [2:0] a);
        reg_addr_i = a;
        #0.5;
        chk(tag, reg_rdata_o, mread(a));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        m_flag = '0; m_en = '0; m_sel = '0; m_gate = '0; m_aflag = '0; m_aen = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10 lines after reset", {30'h0, irq_line_o}, 32'h0);
        chk("R10 aux after reset", {31'h0, irq_aux_o}, 32'h0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd91));
        @(negedge clk);
        do_reset();
        for (int a = 0; a < 8; a++) rd("R10 register reset value", 3'(a));

        // R1 sticky flag
        step(16'h0008, 2'b00, 0, 0, 0);
        rd("R1 flag set", 3'd0);
        step('0, 2'b00, 0, 0, 0);
        rd("R1 flag sticky", 3'd0);
        // R3 enable, R5 gate default 0 so no request yet
        step('0, 2'b00, 1, 3'd1, 32'h0000_0008);
        rd("R3 enable readback", 3'd1);
        rd("R5 gate reset 0", 3'd3);
        step('0, 2'b00, 1, 3'd3, 32'h1);           // R5 gate line 0
        step('0, 2'b00, 0, 0, 0);                   // R6 line 0 rises
        chk("R6 line0 raised", {30'h0, irq_line_o}, 32'h1);
        // R4 move to line 1 (ungated) then gate it
        step('0, 2'b00, 1, 3'd2, 32'h0000_0008);
        rd("R4 select readback", 3'd2);
        step('0, 2'b00, 1, 3'd3, 32'h2);
        step('0, 2'b00, 0, 0, 0);
        chk("R4 routed to line1", {30'h0, irq_line_o}, 32'h2);
        // R2 write 0 keeps, same-cycle event wins, write 1 clears
        step('0, 2'b00, 1, 3'd0, 32'h0);
        rd("R2 write 0 keeps flag", 3'd0);
        step(16'h0008, 2'b00, 1, 3'd0, 32'h0000_0008);
        rd("R2 event beats clear", 3'd0);
        step('0, 2'b00, 1, 3'd0, 32'h0000_0008);
        rd("R2 write 1 clears", 3'd0);
        step('0, 2'b00, 0, 0, 0);
        chk("R6 line drops after clear", {30'h0, irq_line_o}, 32'h0);
        // R3 disable drops request
        step(16'h0008, 2'b00, 0, 0, 0);
        step('0, 2'b00, 1, 3'd1, 32'h0);
        step('0, 2'b00, 0, 0, 0);
        chk("R3 disabled source silent", {30'h0, irq_line_o}, 32'h0);
        // R7 R8 R9 auxiliary group
        step('0, 2'b01, 0, 0, 0);
        rd("R7 bus error flag", 3'd4);
        step('0, 2'b00, 1, 3'd5, 32'h1);
        rd("R8 set-enable readback", 3'd5);
        rd("R8 clear-enable readback", 3'd6);
        step('0, 2'b00, 0, 0, 0);
        chk("R9 aux raised", {31'h0, irq_aux_o}, 32'h1);
        step('0, 2'b00, 1, 3'd5, 32'h0);
        rd("R8 set write of 0 ignored", 3'd5);
        step('0, 2'b10, 1, 3'd4, 32'h2);
        rd("R7 debug event beats clear", 3'd4);
        step('0, 2'b00, 1, 3'd6, 32'h1);
        rd("R8 clear-enable", 3'd6);
        step('0, 2'b00, 0, 0, 0);
        chk("R9 aux dropped", {31'h0, irq_aux_o}, 32'h0);
        // R11 hole address
        step('0, 2'b00, 1, 3'd7, 32'hFFFF_FFFF);
        rd("R11 hole reads 0", 3'd7);
        for (int a = 0; a < 7; a++) rd("R11 hole write ignored", 3'(a));

        // random mix
        for (int i = 0; i < 2000; i++) begin
            logic [N-1:0] ev;
            logic [1:0]   aev;
            logic [2:0]   a;
            ev  = N'($urandom & $urandom & $urandom);
            aev = 2'($urandom & $urandom);
            a   = 3'($urandom_range(0, 7));
            step(ev, aev, ($urandom_range(0, 2) == 0), a, $urandom);
            if (i % 7 == 0) rd("R1 random flags", 3'd0);
            if (i % 11 == 0) rd("R3 random regs", 3'($urandom_range(0, 7)));
            if (i == 1000) begin
                do_reset();
                rd("R10 flags cleared mid-run", 3'd0);
                rd("R10 aux cleared mid-run", 3'd4);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule